// File: doc/BRIEF.md
# Clock Source Controller with Wakeup Fallback

This block controls two on-chip oscillators, an internal RC and an external crystal. For each one it holds the enable bit, reports the ready flag and raises a ready interrupt. It also picks the system clock from the RC, the crystal or a PLL. Oscillator stabilization is modelled by a start-up counter per oscillator, with a length set by a parameter. The RC counter defaults to a shorter length than the crystal counter. Until an oscillator is ready, its clock is held low at the gated output.

Software writes a requested source code. The active select follows the request as soon as the requested source is ready. Until then the request stays pending. When the wake fallback enable is set, a wakeup pulse from a low-power mode forces the system clock onto the RC and turns the RC on. The controller then returns to the requested source in the cycle after that source reports ready. The internal RC cannot be turned off while the system clock depends on it.

Top module: `clksrc_ctrl`

## Requirements
- R1: Register map. Address 0 is control: bit0 RC enable, bit1 crystal enable, bit2 wake fallback enable, bits5:4 requested source. Address 1 is read-only status: bit0 RC ready, bit1 crystal ready, bit2 PLL lock, bits5:4 active source, bit6 forced. Address 2 is interrupt: bit0 RC interrupt enable and bit1 crystal interrupt enable, both read/write; bit8 RC flag and bit9 crystal flag, both write-1-to-clear. Source codes are 00 RC, 01 crystal, 10 PLL. After reset, control reads 0x0001, the interrupt register reads 0, the active source is 00 and irq_o is 0.
- R2: An oscillator's ready flag reads 1 exactly N clock edges after its enable register becomes 1. N is RC_STARTUP for the RC and XTAL_STARTUP for the crystal. Leaving reset counts as the RC being enabled.
- R3: Each gated oscillator clock output stays 0 while that oscillator is not ready, and follows its clock input once it is ready.
- R4: Clearing an enable drops the matching ready flag at the next edge. Enabling it again needs the full start-up count again.
- R5: A ready flag rising sets the sticky interrupt flag one edge later, but only if that oscillator's interrupt enable is 1. irq_o is the OR of the flags. Writing 1 to a flag bit clears it.
- R6: When the requested source is ready, the active source takes its code at the second edge after the control write. A request for a source that is not ready is held, and it takes effect at the edge after that source becomes ready. A requested code of 11 is ignored and the previous request is kept.
- R7: A wakeup pulse with wake fallback enabled sets the active source to 00, sets forced and sets the RC enable, all at the next edge.
- R8: While forced, the active source returns to the requested code, and forced clears, at the edge after the requested source is ready.
- R9: A wakeup pulse with wake fallback disabled changes neither the active source nor forced.
- R10: A control write can leave RC enable at 0 only if, at that edge, RC is not the active source, forced is 0, and the request after the write is not 00. Otherwise RC enable reads 1 after the write, and the write's other fields still apply.
- R11: A PLL request (10) is judged ready by the PLL lock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| wake_i | input | 1 | One-cycle pulse on exit from a low-power mode |
| rc_clk_i | input | 1 | Internal RC oscillator clock |
| xtal_clk_i | input | 1 | Crystal oscillator clock |
| pll_lock_i | input | 1 | PLL lock indication |
| rc_clk_o | output | 1 | RC clock, gated by RC ready |
| xtal_clk_o | output | 1 | Crystal clock, gated by crystal ready |
| sys_sel_o | output | 2 | Active system clock source code |
| irq_o | output | 1 | Ready interrupt request |

## Verification
A start-up counter that is off by one shows in the first status read at the exact edge where ready should rise, and the gated clock output moves with it in the same cycle. A missing forced state or a lost request shows on sys_sel_o one or two edges after a wakeup pulse or a control write. The bench samples at that edge, so it cannot miss the error while waiting. A broken RC lock shows in the very next control read as an RC enable bit of 0 where 1 is expected.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_IRQ  = 2'd2;

    typedef enum logic [1:0] {
        SRC_RC   = 2'b00,
        SRC_XTAL = 2'b01,
        SRC_PLL  = 2'b10,
        SRC_BAD  = 2'b11
    } src_e;

    // readiness of every selectable source
    typedef struct packed {
        logic pll;
        logic xtal;
        logic rc;
    } rdy_t;

    typedef struct packed {
        logic [1:0] sel;
        logic       fb_en;
        logic       xtal_en;
        logic       rc_en;
    } ctrl_t;

    function automatic logic src_ready(input src_e s, input rdy_t r);
        case (s)
            SRC_RC:   return r.rc;
            SRC_XTAL: return r.xtal;
            SRC_PLL:  return r.pll;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/clksrc_osc.sv
module clksrc_osc #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic rdy_o,
    output logic rise_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rdy_o  <= 1'b0;
            rise_o <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            if (!en_i) begin
                cnt_q <= '0;
                rdy_o <= 1'b0;
            end else if (!rdy_o) begin
                if (cnt_q == LAST) begin
                    rdy_o  <= 1'b1;
                    rise_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/clksrc_sel.sv
module clksrc_sel
    import clksrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_e req_i,
    input  rdy_t rdy_i,
    input  logic wake_i,
    input  logic fb_en_i,
    output src_e act_o,
    output logic forced_o
);
    logic go_req;
    assign go_req = src_ready(req_i, rdy_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_o    <= SRC_RC;
            forced_o <= 1'b0;
        end else if (wake_i && fb_en_i) begin
            act_o    <= SRC_RC;
            forced_o <= 1'b1;
        end else if (go_req) begin
            act_o    <= req_i;
            forced_o <= 1'b0;
        end
    end
endmodule

// File: rtl/clksrc_regs.sv
module clksrc_regs
    import clksrc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    input  rdy_t               rdy_i,
    input  logic [1:0]         rise_i,
    input  src_e               act_i,
    input  logic               forced_i,
    input  logic               wake_i,
    output ctrl_t              ctrl_o,
    output logic [1:0]         ie_o,
    output logic [1:0]         flag_o
);
    ctrl_t      ctrl_d;
    logic [1:0] flag_d;
    logic       wr_ctrl, wr_irq, rc_lock;
    logic       unused_wbits;

    assign wr_ctrl = we_i && (addr_i == A_CTRL);
    assign wr_irq  = we_i && (addr_i == A_IRQ);
    assign unused_wbits = ^{wdata_i[REG_W-1:10], wdata_i[7:6], wdata_i[3]};

    always_comb begin
        ctrl_d  = ctrl_o;
        rc_lock = 1'b0;
        if (wr_ctrl) begin
            ctrl_d.xtal_en = wdata_i[1];
            ctrl_d.fb_en   = wdata_i[2];
            if (wdata_i[5:4] != SRC_BAD)
                ctrl_d.sel = wdata_i[5:4];
            rc_lock = (act_i == SRC_RC) || forced_i || (ctrl_d.sel == SRC_RC);
            ctrl_d.rc_en = wdata_i[0] || rc_lock;
        end
        if (wake_i && ctrl_o.fb_en)
            ctrl_d.rc_en = 1'b1;
    end

    always_comb begin
        flag_d = flag_o;
        if (wr_irq)
            flag_d = flag_d & ~wdata_i[9:8];
        flag_d = flag_d | (rise_i & ie_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '{sel: SRC_RC, fb_en: 1'b0, xtal_en: 1'b0, rc_en: 1'b1};
            ie_o   <= '0;
            flag_o <= '0;
        end else begin
            ctrl_o <= ctrl_d;
            flag_o <= flag_d;
            if (wr_irq)
                ie_o <= wdata_i[1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[0]   = ctrl_o.rc_en;
                rdata_o[1]   = ctrl_o.xtal_en;
                rdata_o[2]   = ctrl_o.fb_en;
                rdata_o[5:4] = ctrl_o.sel;
            end
            A_STAT: begin
                rdata_o[0]   = rdy_i.rc;
                rdata_o[1]   = rdy_i.xtal;
                rdata_o[2]   = rdy_i.pll;
                rdata_o[5:4] = act_i;
                rdata_o[6]   = forced_i;
            end
            A_IRQ: begin
                rdata_o[1:0] = ie_o;
                rdata_o[9:8] = flag_o;
            end
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
    import clksrc_pkg::*;
#(
    parameter int unsigned RC_STARTUP   = 8,
    parameter int unsigned XTAL_STARTUP = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              wake_i,
    input  logic              rc_clk_i,
    input  logic              xtal_clk_i,
    input  logic              pll_lock_i,
    output logic              rc_clk_o,
    output logic              xtal_clk_o,
    output logic [1:0]        sys_sel_o,
    output logic              irq_o
);
    localparam int unsigned N_OSC = 2;

    ctrl_t            ctrl_s;
    rdy_t             rdy_s;
    src_e             act_s;
    logic             forced_s;
    logic [N_OSC-1:0] en_s, rdy_osc, rise_s, ie_s, flag_s;
    logic [1:0]       req_s;
    logic             fb_en_s;

    // index 0: internal RC, index 1: crystal
    assign en_s    = {ctrl_s.xtal_en, ctrl_s.rc_en};
    assign req_s   = ctrl_s.sel;
    assign fb_en_s = ctrl_s.fb_en;

    for (genvar g = 0; g < N_OSC; g++) begin : g_osc
        localparam int unsigned LIM = (g == 0) ? RC_STARTUP : XTAL_STARTUP;
        clksrc_osc #(.LIMIT(LIM)) u_osc (
            .clk    (clk),
            .rst    (rst),
            .en_i   (en_s[g]),
            .rdy_o  (rdy_osc[g]),
            .rise_o (rise_s[g])
        );
    end

    assign rdy_s.rc   = rdy_osc[0];
    assign rdy_s.xtal = rdy_osc[1];
    assign rdy_s.pll  = pll_lock_i;

    clksrc_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .req_i    (src_e'(ctrl_s.sel)),
        .rdy_i    (rdy_s),
        .wake_i   (wake_i),
        .fb_en_i  (ctrl_s.fb_en),
        .act_o    (act_s),
        .forced_o (forced_s)
    );

    clksrc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .rdy_i    (rdy_s),
        .rise_i   (rise_s),
        .act_i    (act_s),
        .forced_i (forced_s),
        .wake_i   (wake_i),
        .ctrl_o   (ctrl_s),
        .ie_o     (ie_s),
        .flag_o   (flag_s)
    );

    assign rc_clk_o   = rc_clk_i & rdy_osc[0];
    assign xtal_clk_o = xtal_clk_i & rdy_osc[1];
    assign sys_sel_o  = act_s;
    assign irq_o      = |flag_s;
endmodule

// File: rtl/clksrc_chk.sv
module clksrc_chk
    import clksrc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] sel,
    input logic [1:0] req,
    input logic [2:0] rdy,
    input logic [1:0] en,
    input logic [1:0] ie,
    input logic [1:0] flag,
    input logic       wake,
    input logic       fb_en,
    input logic       forced
);
    // R10
    rc_kept_on_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b00) |-> en[0]);

    // R6
    xtal_only_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b01 && $past(sel) != 2'b01) |-> $past(rdy[1]));

    // R4
    xtal_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !en[1] |=> !rdy[1]);

    // R5
    xtal_flag_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[1]) |-> $past(ie[1]));

    // R5
    rc_flag_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[0]) |-> $past(ie[0]));

    // R7
    wake_force_chk: assert property (@(posedge clk) disable iff (rst)
        (wake && fb_en) |=> (sel == 2'b00 && forced && en[0]));

    // R8
    forced_return_chk: assert property (@(posedge clk) disable iff (rst)
        (forced && !(wake && fb_en) && src_ready(src_e'(req), rdy_t'(rdy)))
            |=> (sel == $past(req) && !forced));
endmodule

bind clksrc_ctrl clksrc_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sys_sel_o),
    .req    (req_s),
    .rdy    (rdy_s),
    .en     (en_s),
    .ie     (ie_s),
    .flag   (flag_s),
    .wake   (wake_i),
    .fb_en  (fb_en_s),
    .forced (forced_s)
);

// File: tb/sim_clksrc_ctrl.sv
module sim_clksrc_ctrl;
    localparam int RS = 6;
    localparam int XS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        wake_i = 1'b0;
    logic        rc_clk_i = 1'b1;
    logic        xtal_clk_i = 1'b1;
    logic        pll_lock_i = 1'b0;
    logic        rc_clk_o, xtal_clk_o, irq_o;
    logic [1:0]  sys_sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clksrc_ctrl #(.RC_STARTUP(RS), .XTAL_STARTUP(XS)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_i(wake_i),
        .rc_clk_i(rc_clk_i), .xtal_clk_i(xtal_clk_i), .pll_lock_i(pll_lock_i),
        .rc_clk_o(rc_clk_o), .xtal_clk_o(xtal_clk_o), .sys_sel_o(sys_sel_o),
        .irq_o(irq_o)
    );

    function automatic logic [15:0] cw(input logic rc, input logic xt,
                                       input logic fb, input logic [1:0] s);
        return {10'b0, s, 1'b0, fb, xt, rc};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_wake();
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); chk("R1 ctrl reset", v, 16'h0001);
        rd(2'd2, v); chk("R1 irq reg reset", v, 16'h0000);
        chk("R1 select reset", sys_sel_o, 2'b00);
        chk("R1 irq_o reset", irq_o, 1'b0);
    endtask

    task automatic t_rc_start();
        logic [15:0] v;
        edges(RS - 1);
        rd(2'd1, v); chk("R2 rc not ready early", v[0], 1'b0);
        chk("R3 rc clk gated", rc_clk_o, 1'b0);
        edges(1);
        rd(2'd1, v); chk("R2 rc ready on time", v[0], 1'b1);
        chk("R3 rc clk passes", rc_clk_o, 1'b1);
        edges(2);
        chk("R5 no flag without enable", irq_o, 1'b0);
    endtask

    task automatic t_xtal_start();
        logic [15:0] v;
        wr(2'd2, 16'h0002);
        wr(2'd0, cw(1, 1, 0, 2'b00));
        edges(XS - 1);
        rd(2'd1, v); chk("R2 xtal not ready early", v[1], 1'b0);
        chk("R3 xtal clk gated", xtal_clk_o, 1'b0);
        edges(1);
        rd(2'd1, v); chk("R2 xtal ready on time", v[1], 1'b1);
        chk("R3 xtal clk passes", xtal_clk_o, 1'b1);
        chk("R5 flag not yet", irq_o, 1'b0);
        edges(1);
        chk("R5 irq raised", irq_o, 1'b1);
        rd(2'd2, v); chk("R5 xtal flag bit", v[9:8], 2'b10);
        edges(3);
        chk("R5 flag sticky", irq_o, 1'b1);
        wr(2'd2, 16'h0202);
        chk("R5 w1c clears", irq_o, 1'b0);
    endtask

    task automatic t_switch();
        wr(2'd0, cw(1, 1, 0, 2'b01));
        chk("R6 not before second edge", sys_sel_o, 2'b00);
        edges(1);
        chk("R6 switch to xtal", sys_sel_o, 2'b01);
    endtask

    task automatic t_pending();
        logic [15:0] v;
        wr(2'd0, cw(1, 1, 0, 2'b10));
        edges(4);
        chk("R6 pll pending held", sys_sel_o, 2'b01);
        pll_lock_i = 1'b1;
        edges(1);
        chk("R11 pll taken on lock", sys_sel_o, 2'b10);
        wr(2'd0, cw(1, 1, 0, 2'b11));
        rd(2'd0, v); chk("R6 code 11 ignored", v[5:4], 2'b10);
        edges(1);
        chk("R6 select unchanged by 11", sys_sel_o, 2'b10);
    endtask

    task automatic t_restart();
        logic [15:0] v;
        wr(2'd2, 16'h0000);
        wr(2'd0, cw(1, 0, 0, 2'b10));
        rd(2'd1, v); chk("R4 ready still set", v[1], 1'b1);
        edges(1);
        rd(2'd1, v); chk("R4 ready drops", v[1], 1'b0);
        wr(2'd0, cw(1, 1, 0, 2'b10));
        edges(XS - 1);
        rd(2'd1, v); chk("R4 full count again", v[1], 1'b0);
        edges(1);
        rd(2'd1, v); chk("R4 ready after recount", v[1], 1'b1);
        edges(2);
        chk("R5 no flag with enable off", irq_o, 1'b0);
    endtask

    task automatic t_wake();
        logic [15:0] v;
        pulse_wake();
        chk("R9 no force without enable", sys_sel_o, 2'b10);
        rd(2'd1, v); chk("R9 forced stays 0", v[6], 1'b0);
        pll_lock_i = 1'b0;
        wr(2'd0, cw(0, 1, 1, 2'b10));
        edges(1);
        rd(2'd1, v); chk("R10 rc off allowed", v[0], 1'b0);
        pulse_wake();
        chk("R7 forced to rc", sys_sel_o, 2'b00);
        rd(2'd1, v); chk("R7 forced flag", v[6], 1'b1);
        rd(2'd0, v); chk("R7 rc enabled by wake", v[0], 1'b1);
        edges(3);
        chk("R8 waits for source", sys_sel_o, 2'b00);
        pll_lock_i = 1'b1;
        edges(1);
        chk("R8 returns to pll", sys_sel_o, 2'b10);
        rd(2'd1, v); chk("R8 forced cleared", v[6], 1'b0);
    endtask

    task automatic t_guard();
        logic [15:0] v;
        edges(RS + 1);
        wr(2'd0, cw(0, 1, 0, 2'b10));
        rd(2'd0, v); chk("R10 rc off while unused", v[0], 1'b0);
        edges(1);
        wr(2'd0, cw(0, 1, 0, 2'b00));
        rd(2'd0, v); chk("R10 rc kept when requested", v[0], 1'b1);
        edges(RS);
        chk("R6 rc pending", sys_sel_o, 2'b10);
        edges(1);
        chk("R6 rc taken when ready", sys_sel_o, 2'b00);
        wr(2'd0, cw(0, 1, 0, 2'b01));
        rd(2'd0, v); chk("R10 rc kept while active", v[0], 1'b1);
        chk("R10 other fields applied", v[5:4], 2'b01);
        edges(1);
        chk("R6 moved to xtal", sys_sel_o, 2'b01);
        wr(2'd0, cw(0, 1, 0, 2'b01));
        rd(2'd0, v); chk("R10 rc off once unused", v[0], 1'b0);
    endtask

    initial begin
        edges(3);
        rst = 1'b0;
        t_reset();
        t_rc_start();
        t_xtal_start();
        t_switch();
        t_pending();
        t_restart();
        t_wake();
        t_guard();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule